// File: doc/BRIEF.md
# Slip-Spacing Lock Detector

This block decides whether a phase-locked loop is in lock by watching a stream of single-cycle cycle-slip pulses from an external phase comparator. A free-running interval timer is restarted by every slip. Lock is declared only after the timer has run past a retrigger time, with no slip in between. The retrigger time comes from a small table of parameters, indexed by the loop-bandwidth code, so a narrow loop must stay quiet for longer than a wide one before lock is declared.

The loss-of-lock output goes active at once on any slip. Once active, it stays active for a guaranteed minimum number of cycles. It is also held active for as long as a calibration-busy flag is high. The output comes straight from a two-state register, so downstream logic can sample it directly. The bandwidth code is expected to change only rarely and needs no synchronization.

Top module: `slip_lock_detect`

## Requirements
- R1: While `rst_n` is low, `lol_o` is 1, and the interval timer and pulse counter read zero. After reset is released, `lol_o` first reads 0 after the edge that follows N = max(RETRIG+1, MIN_PULSE) edges, where RETRIG is the entry selected by the bandwidth code.
- R2: A slip sampled high on a clock edge restarts the interval timer from zero and makes `lol_o` read 1 after that same edge, whatever the previous lock state.
- R3: `lol_o` falls only on an edge where the timer has counted more than RETRIG cycles since the last slip. Counted from the slip edge, `lol_o` stays 1 for max(RETRIG+1, MIN_PULSE)+1 cycles. A second slip inside that window restarts the count from the second slip.
- R4: While `cal_busy_i` is high, `lol_o` is 1. After the last edge that samples `cal_busy_i` high, with the timer already past RETRIG, `lol_o` stays 1 for MIN_PULSE+1 more cycles.
- R5: Each event that asserts loss of lock (a slip or calibration) restarts the pulse counter. `lol_o` cannot fall until that counter has reached MIN_PULSE.
- R6: Codes 0 to NUM_BW-1 select RETRIG_TBL[code]. Any larger code selects the largest entry of the table (default table 12, 30, 60, 100 cycles, so 100).
- R7: The interval timer saturates at its all-ones value and does not wrap. Once lock is declared, `lol_o` stays 0 for any length of slip-free, calibration-free time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slip_i | input | 1 | Cycle-slip pulse from the phase comparator |
| cal_busy_i | input | 1 | Calibration in progress; forces loss of lock |
| bw_code_i | input | BW_W | Loop-bandwidth code that selects the retrigger time |
| lol_o | output | 1 | Loss of lock, active high |

## Verification
The stimulus runs under every table entry and under two unknown codes. For each case it measures how many cycles the loss-of-lock output stays high after a slip. A design that compared with >= instead of >, or that ignored the pulse floor, would release one cycle early or release at RETRIG for the narrowest code. A second slip inside the validation window catches a timer that is not restarted. A lookup that wrapped unknown codes would show a short hold instead of the longest one. Calibration is held long and then dropped, which catches a design that lets calibration end without restarting the pulse floor. A wait of more than the timer's full range catches a counter that wraps and falsely re-enters loss of lock.

// File: rtl/slk_pkg.sv
package slk_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_state_e;

  function automatic int unsigned larger_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/slk_retrig_select.sv
module slk_retrig_select #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BW_W   = 3,
  parameter int unsigned NUM_BW = 4,
  parameter int unsigned RETRIG_TBL [NUM_BW] = '{12, 30, 60, 100}
) (
  input  logic [BW_W-1:0]  bw_code_i,
  output logic [CNT_W-1:0] retrig_o
);
  import slk_pkg::*;

  function automatic int unsigned table_peak();
    int unsigned peak;
    peak = 0;
    for (int i = 0; i < int'(NUM_BW); i++) peak = larger_of(peak, RETRIG_TBL[i]);
    return peak;
  endfunction

  localparam int unsigned TBL_PEAK = table_peak();

  logic [CNT_W-1:0] entry [NUM_BW];

  for (genvar g = 0; g < int'(NUM_BW); g++) begin : g_entry
    assign entry[g] = CNT_W'(RETRIG_TBL[g]);
  end

  always_comb begin
    retrig_o = CNT_W'(TBL_PEAK);
    for (int i = 0; i < int'(NUM_BW); i++) begin
      if (32'(bw_code_i) == i) retrig_o = entry[i];
    end
  end

endmodule

// File: rtl/slk_interval_timer.sv
module slk_interval_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] retrig_i,
  output logic             quiet_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  function automatic logic [CNT_W-1:0] sat_step(logic [CNT_W-1:0] v);
    return (v == CNT_TOP) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= sat_step(cnt_q);
  end

  assign count_o = cnt_q;
  assign quiet_o = (cnt_q > retrig_i);

  // R2: a slip restarts the interval count
  p_timer_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (count_o == '0));

  // R7: the count parks at its top value instead of wrapping
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_TOP) && !restart_i |=> (count_o == CNT_TOP));

endmodule

// File: rtl/slk_pulse_guard.sv
module slk_pulse_guard #(
  parameter int unsigned MIN_PULSE = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned PW_W = $clog2(MIN_PULSE + 2);
  localparam logic [PW_W-1:0] PW_GOAL = PW_W'(MIN_PULSE);

  function automatic logic [PW_W-1:0] floor_step(logic [PW_W-1:0] v);
    return (v >= PW_GOAL) ? v : v + 1'b1;
  endfunction

  logic [PW_W-1:0] pw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pw_q <= '0;
    else if (clear_i) pw_q <= '0;
    else if (run_i)   pw_q <= floor_step(pw_q);
  end

  assign done_o = (pw_q >= PW_GOAL);

  // R5: an asserting event removes any credit toward the pulse floor
  p_floor_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !done_o);

endmodule

// File: rtl/slip_lock_detect.sv
module slip_lock_detect #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BW_W      = 3,
  parameter int unsigned NUM_BW    = 4,
  parameter int unsigned RETRIG_TBL [NUM_BW] = '{12, 30, 60, 100},
  parameter int unsigned MIN_PULSE = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slip_i,
  input  logic            cal_busy_i,
  input  logic [BW_W-1:0] bw_code_i,
  output logic            lol_o
);
  import slk_pkg::*;

  logic [CNT_W-1:0] retrig;
  logic [CNT_W-1:0] interval;
  logic             quiet;
  logic             floor_met;
  logic             force_loss;
  logic             release_ok;
  lock_state_e      state_q;
  lock_state_e      state_d;

  assign force_loss = slip_i | cal_busy_i;
  assign release_ok = quiet & floor_met;

  slk_retrig_select #(
    .CNT_W(CNT_W), .BW_W(BW_W), .NUM_BW(NUM_BW), .RETRIG_TBL(RETRIG_TBL)
  ) u_sel (
    .bw_code_i(bw_code_i),
    .retrig_o (retrig)
  );

  slk_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(slip_i),
    .retrig_i (retrig),
    .quiet_o  (quiet),
    .count_o  (interval)
  );

  slk_pulse_guard #(.MIN_PULSE(MIN_PULSE)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(force_loss),
    .run_i  (state_q == ST_HUNT),
    .done_o (floor_met)
  );

  always_comb begin
    state_d = state_q;
    if (force_loss)                              state_d = ST_HUNT;
    else if (state_q == ST_HUNT && release_ok)   state_d = ST_LOCK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HUNT;
    else        state_q <= state_d;
  end

  assign lol_o = (state_q == ST_HUNT);

  // R2: a slip makes loss of lock visible on the next cycle
  p_slip_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slip_i |=> lol_o);

  // R4: calibration holds loss of lock
  p_cal_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy_i |=> lol_o);

  // R3: release only after the slip-free interval passed the retrigger time
  p_release_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol_o) |-> $past(interval > retrig));

  // R5: release only once the pulse floor was met
  p_release_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol_o) |-> $past(floor_met));

endmodule

// File: tb/sim_slip_lock_detect.sv
module sim_slip_lock_detect;

  localparam int unsigned MINP = 20;
  localparam int unsigned TBL [4] = '{12, 30, 60, 100};
  localparam int NV = 8;
  localparam int VBW  [NV] = '{0, 1, 2, 3, 4, 7, 1, 2};
  localparam int VGAP [NV] = '{0, 0, 0, 0, 0, 0, 5, 25};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slip = 1'b0;
  logic       cal = 1'b0;
  logic [2:0] bw = 3'd0;
  logic       lol;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  slip_lock_detect u0 (
    .clk(clk), .rst_n(rst_n), .slip_i(slip), .cal_busy_i(cal),
    .bw_code_i(bw), .lol_o(lol)
  );

  always #2 clk = ~clk;

  // Hold length restated from the requirements: the larger of the quiet
  // threshold and the pulse floor, plus the cycle of the slip edge itself.
  function automatic int hold_after_slip(int code);
    int r;
    r = 100;
    if (code < 4) r = TBL[code];
    if (r + 1 < MINP) return MINP + 1;
    return r + 2;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic slip_pulse();
    slip = 1'b1;
    @(negedge clk);
    slip = 1'b0;
  endtask

  task automatic measure_high(output int n);
    n = 0;
    while (lol && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic reach_lock();
    int n;
    measure_high(n);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int n;
    bw = 3'd2;
    repeat (4) @(negedge clk);
    check("R1 reset lol", int'(lol), 1);
    rst_n = 1'b1;
    @(negedge clk);
    measure_high(n);
    check("R1 release after reset", n, 61);

    // vector walk over bandwidth codes and slip spacing
    for (int v = 0; v < NV; v++) begin
      reach_lock();
      bw = VBW[v][2:0];
      repeat (2) @(negedge clk);
      check("R7 locked before slip", int'(lol), 0);
      slip_pulse();
      check("R2 slip asserts lol", int'(lol), 1);
      if (VGAP[v] > 0) begin
        repeat (VGAP[v]) @(negedge clk);
        slip_pulse();
      end
      measure_high(n);
      check(VGAP[v] > 0 ? "R3 restart on second slip" : "R3 R6 hold per code",
            n, hold_after_slip(VBW[v]));
    end

    // calibration held long, timer already quiet
    reach_lock();
    bw = 3'd0;
    @(negedge clk);
    cal = 1'b1;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (i == 149) check("R4 lol during cal", int'(lol), 1);
    end
    cal = 1'b0;
    measure_high(n);
    check("R4 R5 floor after cal", n, MINP + 1);

    // narrow code: pulse floor dominates the quiet threshold
    reach_lock();
    bw = 3'd0;
    @(negedge clk);
    slip_pulse();
    measure_high(n);
    check("R5 floor dominates", n, MINP + 1);

    // long slip-free run beyond the timer range
    reach_lock();
    repeat (70000) @(negedge clk);
    check("R7 no wrap", int'(lol), 0);
    slip_pulse();
    check("R2 slip after saturation", int'(lol), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule